// File: doc/BRIEF.md
# Scalar-to-Element Loop Sequencer

This block sits between an instruction decoder and the execution pipelines. It turns one ordinary scalar instruction into a short burst of element operations, so the core gets vector-style execution without any vector opcodes. A small control register holds the loop length, from 1 to 8. When an instruction is accepted, the sequencer captures the opcode and its three register numbers. It then emits one element operation per cycle. Element k uses every register number raised by k, wrapping modulo the register-file size.

Each element that consumes and produces a carry is tied to its own bit of an 8-bit carry vector. The sequencer hands bit k to element k as its carry-in. The execution side returns the carry-out through an update port. The whole vector is also a special register: software can read it and overwrite it, so the carries survive a context switch.

Condition results are steered to field 6 while a loop of more than one element runs. A length of 1 is plain scalar issue and uses field 0.

Top module: `elem_loop_seq`

## Requirements
- R1: Element k of an accepted instruction carries rd+k, ra+k and rb+k, each taken modulo 32. Its opcode, record flag and carry-use flag equal those of the accepted instruction.
- R2: Writing vl_wr_data sets the loop length to vl_wr_data+1, and vlen_o shows it from the next cycle. The length is captured when an instruction is accepted, so a write during a loop does not change that loop.
- R3: An accepted instruction of length L produces exactly L element operations. They are numbered 0 to L-1 on out_elem, and out_last is high only on element L-1. With out_ready held high, one element is emitted per cycle, starting the cycle after acceptance.
- R4: in_ready is low from the cycle after acceptance until the cycle after the final element is taken (out_valid and out_ready both high). It is high again in that cycle.
- R5: While out_valid is high and out_ready is low, the element index and every element output hold their values.
- R6: With length 1, the instruction is emitted once, unchanged, with out_last high and condition field 0.
- R7: out_cr_field is 6 for every element of a loop of length greater than 1, and 0 for length 1.
- R8: out_carry_in for element k equals bit k of the carry vector in that cycle.
- R9: An update on cy_upd_en writes cy_upd_val into bit cy_upd_idx of the carry vector from the next cycle. The other bits are left unchanged.
- R10: spr_rd_data always shows the carry vector. A write on spr_wr_en replaces the whole vector and wins over a bit update in the same cycle.
- R11: A cycle with rst high clears the busy state, the element index and the carry vector, and sets the loop length to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vl_wr_en | input | 1 | Loop length register write strobe |
| vl_wr_data | input | 3 | Loop length minus one |
| vlen_o | output | 4 | Current loop length, 1 to 8 |
| in_valid | input | 1 | Scalar instruction offered |
| in_ready | output | 1 | Sequencer can accept an instruction |
| in_opcode | input | 6 | Scalar opcode |
| in_rd | input | 5 | Destination register number |
| in_ra | input | 5 | First source register number |
| in_rb | input | 5 | Second source register number |
| in_rc | input | 1 | Instruction records a condition result |
| in_cy | input | 1 | Instruction uses carry in and out |
| out_valid | output | 1 | Element operation offered |
| out_ready | input | 1 | Downstream takes the element |
| out_opcode | output | 6 | Opcode of the element |
| out_rd | output | 5 | Destination register of the element |
| out_ra | output | 5 | First source register of the element |
| out_rb | output | 5 | Second source register of the element |
| out_rc | output | 1 | Element records a condition result |
| out_cy | output | 1 | Element uses carry |
| out_elem | output | 3 | Element index |
| out_last | output | 1 | Final element of the loop |
| out_cr_field | output | 3 | Condition field the result targets |
| out_carry_in | output | 1 | Carry-in bit for this element |
| cy_upd_en | input | 1 | Element carry-out write strobe |
| cy_upd_idx | input | 3 | Carry bit to write |
| cy_upd_val | input | 1 | Carry-out value |
| spr_wr_en | input | 1 | Carry special register write strobe |
| spr_wr_data | input | 8 | New carry vector |
| spr_rd_data | output | 8 | Current carry vector |

## Verification
The handshake assertions assume that downstream may hold out_ready low for any number of cycles. They also assume that the bench keeps in_valid low while the sequencer is busy. The bench drives every input one time unit after a rising edge and samples the outputs there too. This way each stall, update and write lines up with a known edge. The register-step property takes for granted that element outputs are only compared between two consecutive taken elements of the same loop. The bench supplies carry updates only for indices in the 0 to 7 range. It makes them coincide with special register writes only in the priority test, where that collision is the point.

// File: rtl/elem_loop_pkg.sv
package elem_loop_pkg;
    localparam int REG_W   = 5;
    localparam int OP_W    = 6;
    localparam int MAX_VL  = 8;
    localparam int IDX_W   = $clog2(MAX_VL);
    localparam int VL_W    = $clog2(MAX_VL + 1);
    localparam int CR_W    = 3;
    localparam logic [CR_W-1:0] CR_LOOP   = 3'd6;
    localparam logic [CR_W-1:0] CR_SCALAR = 3'd0;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] ra;
        logic [REG_W-1:0] rb;
        logic             rc;
        logic             cy;
    } instr_t;

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] last;
        instr_t           ins;
    } seq_state_t;
endpackage

// File: rtl/vlen_reg.sv
module vlen_reg
    import elem_loop_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_data,
    output logic [IDX_W-1:0] len_m1,
    output logic [VL_W-1:0]  vlen_o
);
    logic [IDX_W-1:0] m1_d, m1_q;

    always_comb begin
        m1_d = m1_q;
        if (wr_en) begin
            m1_d = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            m1_q <= '0;
        end else begin
            m1_q <= m1_d;
        end
    end

    assign len_m1 = m1_q;
    assign vlen_o = VL_W'(m1_q) + VL_W'(1);

    // R2
    vl_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> vlen_o == VL_W'($past(wr_data)) + VL_W'(1));
endmodule

// File: rtl/issue_ctrl.sv
module issue_ctrl
    import elem_loop_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] len_m1,
    input  logic             in_valid,
    output logic             in_ready,
    input  instr_t           in_ins,
    output logic             out_valid,
    input  logic             out_ready,
    output instr_t           out_ins,
    output logic [IDX_W-1:0] out_idx,
    output logic             out_last,
    output logic             looping
);
    seq_state_t s_d, s_q;
    logic accept, take, at_end;

    always_comb begin
        s_d    = s_q;
        accept = in_valid && !s_q.busy;
        take   = s_q.busy && out_ready;
        at_end = (s_q.idx == s_q.last);
        if (accept) begin
            s_d.busy = 1'b1;
            s_d.idx  = '0;
            s_d.last = len_m1;
            s_d.ins  = in_ins;
        end else if (take) begin
            if (at_end) begin
                s_d.busy = 1'b0;
                s_d.idx  = '0;
            end else begin
                s_d.idx = s_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready  = !s_q.busy;
    assign out_valid = s_q.busy;
    assign out_ins   = s_q.ins;
    assign out_idx   = s_q.idx;
    assign out_last  = s_q.busy && at_end;
    assign looping   = (s_q.last != '0);

    // R3
    first_elem_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_valid && out_idx == '0));

    // R4
    ready_return_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> in_ready);

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_idx) && $stable(out_ins)));
endmodule

// File: rtl/carry_spr.sv
module carry_spr
    import elem_loop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic              upd_val,
    input  logic              wr_en,
    input  logic [MAX_VL-1:0] wr_data,
    output logic [MAX_VL-1:0] vec
);
    logic [MAX_VL-1:0] vec_d, vec_q;

    for (genvar b = 0; b < MAX_VL; b++) begin : g_bit
        always_comb begin
            vec_d[b] = vec_q[b];
            if (wr_en) begin
                vec_d[b] = wr_data[b];
            end else if (upd_en && upd_idx == IDX_W'(b)) begin
                vec_d[b] = upd_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
        end else begin
            vec_q <= vec_d;
        end
    end

    assign vec = vec_q;

    // R10
    spr_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> vec == $past(wr_data));

    // R9
    bit_update_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !wr_en) |=> vec[$past(upd_idx)] == $past(upd_val));
endmodule

// File: rtl/elem_loop_seq.sv
module elem_loop_seq
    import elem_loop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              vl_wr_en,
    input  logic [IDX_W-1:0]  vl_wr_data,
    output logic [VL_W-1:0]   vlen_o,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [OP_W-1:0]   in_opcode,
    input  logic [REG_W-1:0]  in_rd,
    input  logic [REG_W-1:0]  in_ra,
    input  logic [REG_W-1:0]  in_rb,
    input  logic              in_rc,
    input  logic              in_cy,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [OP_W-1:0]   out_opcode,
    output logic [REG_W-1:0]  out_rd,
    output logic [REG_W-1:0]  out_ra,
    output logic [REG_W-1:0]  out_rb,
    output logic              out_rc,
    output logic              out_cy,
    output logic [IDX_W-1:0]  out_elem,
    output logic              out_last,
    output logic [CR_W-1:0]   out_cr_field,
    output logic              out_carry_in,
    input  logic              cy_upd_en,
    input  logic [IDX_W-1:0]  cy_upd_idx,
    input  logic              cy_upd_val,
    input  logic              spr_wr_en,
    input  logic [MAX_VL-1:0] spr_wr_data,
    output logic [MAX_VL-1:0] spr_rd_data
);
    logic [IDX_W-1:0] len_m1;
    instr_t           in_ins, cur_ins;
    logic             looping;

    assign in_ins = '{op: in_opcode, rd: in_rd, ra: in_ra, rb: in_rb, rc: in_rc, cy: in_cy};

    vlen_reg u_vlen (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (vl_wr_en),
        .wr_data (vl_wr_data),
        .len_m1  (len_m1),
        .vlen_o  (vlen_o)
    );

    issue_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .len_m1    (len_m1),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_ins    (in_ins),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_ins   (cur_ins),
        .out_idx   (out_elem),
        .out_last  (out_last),
        .looping   (looping)
    );

    carry_spr u_carry (
        .clk     (clk),
        .rst     (rst),
        .upd_en  (cy_upd_en),
        .upd_idx (cy_upd_idx),
        .upd_val (cy_upd_val),
        .wr_en   (spr_wr_en),
        .wr_data (spr_wr_data),
        .vec     (spr_rd_data)
    );

    assign out_opcode   = cur_ins.op;
    assign out_rd       = cur_ins.rd + REG_W'(out_elem);
    assign out_ra       = cur_ins.ra + REG_W'(out_elem);
    assign out_rb       = cur_ins.rb + REG_W'(out_elem);
    assign out_rc       = cur_ins.rc;
    assign out_cy       = cur_ins.cy;
    assign out_cr_field = looping ? CR_LOOP : CR_SCALAR;
    assign out_carry_in = spr_rd_data[out_elem];

    // R1
    reg_step_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_last) |=>
            (out_rd == $past(out_rd) + REG_W'(1) && out_ra == $past(out_ra) + REG_W'(1)));

    // R7
    loop_field_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_elem != '0) |-> out_cr_field == CR_LOOP);
endmodule

// File: tb/elem_loop_seq_test.sv
module elem_loop_seq_test;
    logic clk = 1'b0;
    logic rst;
    logic vl_wr_en;
    logic [2:0] vl_wr_data;
    logic [3:0] vlen_o;
    logic in_valid, in_ready;
    logic [5:0] in_opcode;
    logic [4:0] in_rd, in_ra, in_rb;
    logic in_rc, in_cy;
    logic out_valid, out_ready;
    logic [5:0] out_opcode;
    logic [4:0] out_rd, out_ra, out_rb;
    logic out_rc, out_cy;
    logic [2:0] out_elem;
    logic out_last;
    logic [2:0] out_cr_field;
    logic out_carry_in;
    logic cy_upd_en;
    logic [2:0] cy_upd_idx;
    logic cy_upd_val;
    logic spr_wr_en;
    logic [7:0] spr_wr_data, spr_rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    elem_loop_seq uut (.*);

    typedef struct packed {
        logic [3:0] len;
        logic [4:0] rd;
        logic [4:0] ra;
        logic [4:0] rb;
        logic [5:0] op;
        logic       rc;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{len: 4'd1, rd: 5'd3,  ra: 5'd4,  rb: 5'd5,  op: 6'h1F, rc: 1'b1},
        '{len: 4'd2, rd: 5'd10, ra: 5'd11, rb: 5'd12, op: 6'h0E, rc: 1'b1},
        '{len: 4'd4, rd: 5'd30, ra: 5'd29, rb: 5'd28, op: 6'h21, rc: 1'b0},
        '{len: 4'd8, rd: 5'd0,  ra: 5'd31, rb: 5'd16, op: 6'h3A, rc: 1'b1},
        '{len: 4'd8, rd: 5'd24, ra: 5'd25, rb: 5'd26, op: 6'h07, rc: 1'b0},
        '{len: 4'd3, rd: 5'd31, ra: 5'd31, rb: 5'd31, op: 6'h01, rc: 1'b1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic set_len(input int len);
        vl_wr_en   = 1'b1;
        vl_wr_data = 3'(len - 1);
        step();
        vl_wr_en = 1'b0;
    endtask

    task automatic issue(input vec_t v, input logic cy);
        in_valid  = 1'b1;
        in_opcode = v.op;
        in_rd     = v.rd;
        in_ra     = v.ra;
        in_rb     = v.rb;
        in_rc     = v.rc;
        in_cy     = cy;
        step();
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; vl_wr_en = 0; vl_wr_data = 0; in_valid = 0; in_opcode = 0;
        in_rd = 0; in_ra = 0; in_rb = 0; in_rc = 0; in_cy = 0; out_ready = 1;
        cy_upd_en = 0; cy_upd_idx = 0; cy_upd_val = 0; spr_wr_en = 0; spr_wr_data = 0;
        repeat (3) step();
        // R11 reset state
        chk("R11 in_ready after reset", int'(in_ready), 1);
        chk("R11 out_valid after reset", int'(out_valid), 0);
        chk("R11 carry after reset", int'(spr_rd_data), 0);
        chk("R11 length after reset", int'(vlen_o), 1);
        rst = 1'b0;
        step();

        // Table walk: R1 R3 R4 R6 R7
        for (int i = 0; i < NV; i++) begin
            vec_t v = VECS[i];
            set_len(int'(v.len));
            chk("R2 vlen_o", int'(vlen_o), int'(v.len));
            issue(v, 1'b0);
            chk("R4 in_ready low while busy", int'(in_ready), 0);
            for (int k = 0; k < int'(v.len); k++) begin
                chk("R3 out_valid", int'(out_valid), 1);
                chk("R3 out_elem", int'(out_elem), k);
                chk("R3 out_last", int'(out_last), (k == int'(v.len) - 1) ? 1 : 0);
                chk("R1 out_rd", int'(out_rd), (int'(v.rd) + k) % 32);
                chk("R1 out_ra", int'(out_ra), (int'(v.ra) + k) % 32);
                chk("R1 out_rb", int'(out_rb), (int'(v.rb) + k) % 32);
                chk("R1 out_opcode", int'(out_opcode), int'(v.op));
                chk("R1 out_rc", int'(out_rc), int'(v.rc));
                if (v.len == 4'd1) chk("R6 scalar field", int'(out_cr_field), 0);
                else chk("R7 loop field", int'(out_cr_field), 6);
                step();
            end
            chk("R3 no extra element", int'(out_valid), 0);
            chk("R4 in_ready returns", int'(in_ready), 1);
        end

        // R5 backpressure
        set_len(4);
        issue(VECS[2], 1'b0);
        out_ready = 1'b0;
        for (int c = 0; c < 3; c++) begin
            chk("R5 stalled index", int'(out_elem), 0);
            chk("R5 stalled rd", int'(out_rd), 30);
            chk("R5 stalled valid", int'(out_valid), 1);
            step();
        end
        out_ready = 1'b1;
        step();
        chk("R5 resumes at element 1", int'(out_elem), 1);
        chk("R5 rd after resume", int'(out_rd), 31);
        repeat (3) step();
        chk("R5 loop done", int'(out_valid), 0);

        // R2 length captured at accept
        set_len(3);
        issue(VECS[1], 1'b0);
        vl_wr_en = 1'b1; vl_wr_data = 3'd6;
        step();
        vl_wr_en = 1'b0;
        chk("R2 length write during loop", int'(vlen_o), 7);
        step();
        chk("R2 old length kept, last", int'(out_last), 1);
        chk("R2 old length kept, elem", int'(out_elem), 2);
        step();
        chk("R2 loop ended after 3", int'(out_valid), 0);

        // R8 R9 R10 carry vector
        spr_wr_en = 1'b1; spr_wr_data = 8'hA5;
        step();
        spr_wr_en = 1'b0;
        chk("R10 spr readback", int'(spr_rd_data), 8'hA5);
        set_len(8);
        issue(VECS[3], 1'b1);
        for (int k = 0; k < 8; k++) begin
            chk("R8 carry in", int'(out_carry_in), int'((8'hA5 >> k) & 1));
            chk("R1 out_cy", int'(out_cy), 1);
            cy_upd_en = 1'b1; cy_upd_idx = 3'(k); cy_upd_val = ~((8'hA5 >> k) & 1'b1);
            step();
        end
        cy_upd_en = 1'b0;
        chk("R9 carry vector after updates", int'(spr_rd_data), 8'h5A);

        // R10 priority
        spr_wr_en = 1'b1; spr_wr_data = 8'h3C;
        cy_upd_en = 1'b1; cy_upd_idx = 3'd0; cy_upd_val = 1'b1;
        step();
        spr_wr_en = 1'b0;
        chk("R10 write beats update", int'(spr_rd_data), 8'h3C);
        cy_upd_idx = 3'd1;
        step();
        cy_upd_en = 1'b0;
        chk("R9 single bit update", int'(spr_rd_data), 8'h3E);

        // R11 reset mid loop
        set_len(5);
        issue(VECS[4], 1'b0);
        step();
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R11 busy cleared", int'(out_valid), 0);
        chk("R11 ready after reset", int'(in_ready), 1);
        chk("R11 carry cleared", int'(spr_rd_data), 0);
        chk("R11 length reset", int'(vlen_o), 1);
        issue(VECS[0], 1'b0);
        chk("R11 index restarts", int'(out_elem), 0);
        chk("R6 single element last", int'(out_last), 1);
        step();
        chk("R6 single element only", int'(out_valid), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule